// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the software-facing half of an SPI master. A simple single-cycle bus reaches a small bank of 32-bit registers. One register configures the serial engine: word width, clock polarity and phase, bit order, master selection, loopback, enable, a soft reset and the enables of the two queues. One register holds the baud divider. One register masks the single interrupt source. Two buffer offsets move data. A write to the transmit offset queues a word for the shift engine. A read of the receive offset takes the oldest word the engine has delivered.

The serial timing, chip-select drive and any DMA sit outside the block. The shift engine takes transmit words over a valid/ready handshake and hands back received words with a one-cycle valid strobe. It also reports when it is busy. The interrupt tells software that everything it queued has left the shifter, so it can refill the queue or end the transfer.

Top module: `spi_regfront`

## Requirements
- R1: After reset the control, baud and interrupt-enable registers read zero, `irq` is low, `tx_valid` is low and `bus_rdata` is zero.
- R2: Offset 0x000 is the control register. Bits [13:0] are read/write and bits above 13 read zero. The fields are: width-minus-one [3:0], MSB-first 4, phase 5, polarity 6, soft reset 7, master 8, enable 9, loopback 10, TX queue enable 11, RX queue enable 12, stretch-on-receive 13. Each field drives its own configuration output.
- R3: Offset 0x00C holds a 16-bit baud divider that reads back and drives `cfg_baud`. Bits above 15 read zero.
- R4: A write to offset 0x004 queues `bus_wdata[15:0]`. While enable (bit 9) is set and soft reset is clear, queued words appear on `tx_data` with `tx_valid` in write order, and each one leaves on a cycle where `tx_valid` and `tx_ready` are both high.
- R5: The TX queue holds 8 words when bit 11 is set and 1 word when it is clear. Writes to a full queue are dropped.
- R6: A read of offset 0x008 returns the oldest received word, zero-extended, on `bus_rdata` in the cycle after the read, and removes it. A read with nothing pending returns zero and changes nothing.
- R7: A cycle with `rx_valid` high stores `rx_data`. The RX queue holds 8 words when bit 12 is set and 1 word when it is clear. Arrivals while it is full are dropped.
- R8: Offset 0x010 stores bit 2, the transmit-empty interrupt enable, and reads it back. All other bits read zero.
- R9: `irq` is registered and equals bit 2 of offset 0x010 AND TX queue empty AND NOT `shift_busy`, one cycle late. Writing 0 to offset 0x010 drops it.
- R10: While soft reset (bit 7) is set, both queues are empty, writes to offset 0x004 and `rx_valid` arrivals are dropped, `tx_valid` is low and `engine_rst` is high.
- R11: Reads of unmapped offsets, and of offset 0x004, return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_sel | input | 1 | bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered |
| tx_valid | output | 1 | transmit word available to engine |
| tx_ready | input | 1 | engine takes the word |
| tx_data | output | WORD_W | transmit word |
| rx_valid | input | 1 | received word strobe |
| rx_data | input | WORD_W | received word |
| shift_busy | input | 1 | engine is shifting |
| engine_rst | output | 1 | hold engine idle |
| cfg_width_m1 | output | 4 | word width minus one |
| cfg_msb_first | output | 1 | MSB first |
| cfg_phase | output | 1 | clock phase |
| cfg_polarity | output | 1 | clock polarity |
| cfg_master | output | 1 | master mode |
| cfg_enable | output | 1 | engine enable |
| cfg_loopback | output | 1 | internal loopback |
| cfg_rx_stretch | output | 1 | stretch clock on receive |
| cfg_baud | output | 16 | baud divider |
| irq | output | 1 | transmit-empty interrupt level |

## Verification
The assertions assume that `bus_sel` accesses are whole, single-cycle and word-aligned. They also assume that `rx_valid` and `tx_ready` are never X after reset and that `shift_busy` is a clean level. The bench drives every input at the falling edge, so nothing changes near the sampling edge. It changes the control register only between bursts. Random data and random queue fill levels stay within these rules, including the cases that push past full and read past empty.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
  localparam int REG_W  = 32;
  localparam int CTRL_W = 14;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_TXB  = 8'h04;
  localparam logic [7:0] OFF_RXB  = 8'h08;
  localparam logic [7:0] OFF_BAUD = 8'h0C;
  localparam logic [7:0] OFF_IEN  = 8'h10;
  localparam int B_MSB   = 4;
  localparam int B_PHA   = 5;
  localparam int B_POL   = 6;
  localparam int B_SRST  = 7;
  localparam int B_MSTR  = 8;
  localparam int B_EN    = 9;
  localparam int B_LOOP  = 10;
  localparam int B_TXQ   = 11;
  localparam int B_RXQ   = 12;
  localparam int B_STR   = 13;
  localparam int IEN_BIT = 2;
endpackage

// File: rtl/spirf_fifo.sv
module spirf_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         cap_one,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = cap_one ? !empty : (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (count == $past(count))); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty); // R10
endmodule

// File: rtl/spirf_irq.sv
module spirf_irq (
  input  logic clk,
  input  logic rst,
  input  logic ien_bit,
  input  logic tx_empty,
  input  logic busy,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ien_bit && tx_empty && !busy;
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !ien_bit |=> !irq); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !irq); // R9
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int WORD_W  = 16,
  parameter int Q_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              shift_busy,
  output logic              engine_rst,
  output logic [3:0]        cfg_width_m1,
  output logic              cfg_msb_first,
  output logic              cfg_phase,
  output logic              cfg_polarity,
  output logic              cfg_master,
  output logic              cfg_enable,
  output logic              cfg_loopback,
  output logic              cfg_rx_stretch,
  output logic [15:0]       cfg_baud,
  output logic              irq
);
  localparam int PAD = REG_W - WORD_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [15:0]       baud_q;
  logic              ien_q;
  logic              wr_hit, rd_hit;
  logic [7:0]        off;
  logic              srst;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [WORD_W-1:0] rx_head;
  logic              tx_push, tx_pop, rx_pop;
  logic              unused_wbits;

  assign off          = 8'(bus_addr);
  assign wr_hit       = bus_sel && bus_wr;
  assign rd_hit       = bus_sel && !bus_wr;
  assign srst         = ctrl_q[B_SRST];
  assign unused_wbits = ^bus_wdata[31:16] ^ tx_full ^ rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      baud_q <= '0;
      ien_q  <= 1'b0;
    end else if (wr_hit) begin
      case (off)
        OFF_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
        OFF_BAUD: baud_q <= bus_wdata[15:0];
        OFF_IEN:  ien_q  <= bus_wdata[IEN_BIT];
        default:  ;
      endcase
    end
  end

  assign tx_push = wr_hit && (off == OFF_TXB) && !srst;
  assign tx_valid = !tx_empty && ctrl_q[B_EN] && !srst;
  assign tx_pop   = tx_valid && tx_ready;
  assign rx_pop   = rd_hit && (off == OFF_RXB);

  spirf_fifo #(.W(WORD_W), .DEPTH(Q_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(srst), .cap_one(!ctrl_q[B_TXQ]),
    .push(tx_push), .din(bus_wdata[WORD_W-1:0]), .pop(tx_pop),
    .dout(tx_data), .empty(tx_empty), .full(tx_full));

  spirf_fifo #(.W(WORD_W), .DEPTH(Q_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(srst), .cap_one(!ctrl_q[B_RXQ]),
    .push(rx_valid && !srst), .din(rx_data), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full));

  spirf_irq u_irq (
    .clk(clk), .rst(rst), .ien_bit(ien_q), .tx_empty(tx_empty),
    .busy(shift_busy), .irq(irq));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_hit) begin
      case (off)
        OFF_CTRL: bus_rdata <= {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
        OFF_RXB:  bus_rdata <= rx_empty ? '0 : {{PAD{1'b0}}, rx_head};
        OFF_BAUD: bus_rdata <= {16'h0, baud_q};
        OFF_IEN:  bus_rdata <= 32'(ien_q) << IEN_BIT;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign engine_rst     = srst;
  assign cfg_width_m1   = ctrl_q[3:0];
  assign cfg_msb_first  = ctrl_q[B_MSB];
  assign cfg_phase      = ctrl_q[B_PHA];
  assign cfg_polarity   = ctrl_q[B_POL];
  assign cfg_master     = ctrl_q[B_MSTR];
  assign cfg_enable     = ctrl_q[B_EN];
  assign cfg_loopback   = ctrl_q[B_LOOP];
  assign cfg_rx_stretch = ctrl_q[B_STR];
  assign cfg_baud       = baud_q;

  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    engine_rst |-> !tx_valid); // R10
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !(wr_hit && off == OFF_CTRL)) |=> (tx_valid && $stable(tx_data))); // R4
  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> (bus_rdata == '0)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && off == OFF_TXB) |=> (bus_rdata == '0)); // R11
endmodule

// File: tb/sim_spi_regfront.sv
`timescale 1ns/1ps
module sim_spi_regfront;
  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready = 0;
  logic [15:0] tx_data;
  logic rx_valid = 0;
  logic [15:0] rx_data = '0;
  logic shift_busy = 0, engine_rst;
  logic [3:0] cfg_width_m1;
  logic cfg_msb_first, cfg_phase, cfg_polarity, cfg_master, cfg_enable;
  logic cfg_loopback, cfg_rx_stretch, irq;
  logic [15:0] cfg_baud;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_regfront u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a[4:0]; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a[4:0];
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic inject(input logic [15:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  // collects words leaving the TX side; sample at negedge, pop at next posedge
  task automatic drain(ref logic [15:0] got[$]);
    tx_ready = 1;
    for (int i = 0; i < 24; i++) begin
      if (tx_valid) got.push_back(tx_data);
      @(negedge clk);
    end
    tx_ready = 0;
  endtask

  function automatic logic [31:0] ctrl_mask(input logic [31:0] v);
    return v & 32'h0000_3FFF;
  endfunction

  localparam logic [31:0] QEN = 32'h1800, EN = 32'h0200, SRST = 32'h0080;

  initial begin
    logic [31:0] r, v;
    logic [15:0] exp_q[$], got[$];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(8'h00, r); chk("R1 ctrl", r, 0);
    rd(8'h0C, r); chk("R1 baud", r, 0);
    rd(8'h10, r); chk("R1 ien", r, 0);

    // R2 control readback and fields, random
    for (int i = 0; i < 6; i++) begin
      v = $urandom() & ~SRST & ~EN;
      wr(8'h00, v);
      rd(8'h00, r); chk("R2 ctrl readback", r, ctrl_mask(v));
      chk("R2 fields", {cfg_rx_stretch, cfg_loopback, cfg_master, cfg_polarity,
                        cfg_phase, cfg_msb_first, cfg_width_m1},
          {v[13], v[10], v[8], v[6], v[5], v[4], v[3:0]});
    end
    // R3 baud
    v = $urandom(); wr(8'h0C, v);
    rd(8'h0C, r); chk("R3 baud readback", r, v & 32'hFFFF);
    chk("R3 cfg_baud", cfg_baud, v[15:0]);
    // R8 ien
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, r); chk("R8 ien", r, 32'h4);
    wr(8'h10, 0); rd(8'h10, r); chk("R8 ien clear", r, 0);
    // R11 unmapped / TX buffer read
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h14, r); chk("R11 unmapped read", r, 0);
    rd(8'h04, r); chk("R11 txbuf read", r, 0);
    rd(8'h0C, r); chk("R11 baud intact", r, v & 32'hFFFF);

    // R4/R5 TX ordering and full drop, queue enabled
    wr(8'h00, QEN | 32'hF);
    for (int n = 0; n < 3; n++) begin
      int cnt = 1 + ($urandom() % 11);
      exp_q.delete(); got.delete();
      for (int i = 0; i < cnt; i++) begin
        logic [15:0] w = 16'($urandom());
        wr(8'h04, {16'hDEAD, w});
        if (exp_q.size() < 8) exp_q.push_back(w);
      end
      chk("R4 held while disabled", tx_valid, 0);
      wr(8'h00, QEN | EN | 32'hF);
      drain(got);
      chk("R5 count", got.size(), exp_q.size());
      foreach (exp_q[i]) chk("R4 order", (i < got.size()) ? got[i] : 16'hxxxx, exp_q[i]);
      wr(8'h00, QEN | 32'hF);
    end
    // R5 single-word capacity
    wr(8'h00, 32'h7);
    wr(8'h04, 32'h1111); wr(8'h04, 32'h2222);
    got.delete(); wr(8'h00, EN | 32'h7); drain(got);
    chk("R5 cap one count", got.size(), 1);
    chk("R5 cap one data", got.size() > 0 ? got[0] : 16'hxxxx, 16'h1111);

    // R6/R7 RX order and overflow drop
    wr(8'h00, QEN);
    rd(8'h08, r); chk("R6 empty read zero", r, 0);
    exp_q.delete();
    for (int i = 0; i < 10; i++) begin
      logic [15:0] w = 16'($urandom());
      inject(w);
      if (exp_q.size() < 8) exp_q.push_back(w);
    end
    foreach (exp_q[i]) begin rd(8'h08, r); chk("R7 rx order", r, {16'h0, exp_q[i]}); end
    rd(8'h08, r); chk("R6 read past empty", r, 0);
    wr(8'h00, 0);
    inject(16'hAAAA); inject(16'hBBBB);
    rd(8'h08, r); chk("R7 cap one first", r, 32'hAAAA);
    rd(8'h08, r); chk("R7 cap one drop", r, 0);

    // R9 interrupt
    wr(8'h10, 32'h4); repeat (2) @(negedge clk);
    chk("R9 irq empty idle", irq, 1);
    shift_busy = 1; repeat (2) @(negedge clk);
    chk("R9 irq busy low", irq, 0);
    shift_busy = 0; wr(8'h04, 32'h5A5A); repeat (2) @(negedge clk);
    chk("R9 irq low with data", irq, 0);
    got.delete(); wr(8'h00, EN); drain(got); @(negedge clk);
    chk("R9 irq after drain", irq, 1);
    wr(8'h10, 0); @(negedge clk);
    chk("R9 irq masked", irq, 0);

    // R10 soft reset flush
    wr(8'h00, QEN);
    wr(8'h04, 32'h1234); wr(8'h04, 32'h5678); inject(16'h9999);
    wr(8'h00, QEN | EN | SRST);
    chk("R10 engine_rst", engine_rst, 1);
    chk("R10 tx_valid low", tx_valid, 0);
    wr(8'h04, 32'h4321); inject(16'h7777);
    wr(8'h00, QEN | EN);
    chk("R10 engine_rst clear", engine_rst, 0);
    chk("R10 tx flushed", tx_valid, 0);
    rd(8'h08, r); chk("R10 rx flushed", r, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule